// File: doc/BRIEF.md
# Zero-Crossing Direction Detector

This block turns the digitised outputs of two comparators per AC phase into one clean square wave per phase. One comparator rises when the commutating voltage crosses zero going up, the other when it crosses going down. Both arrive asynchronously. The block synchronises them, detects their rising edges and keeps a per-phase level register. That register goes high on an accepted upward crossing and low on an accepted downward crossing. Each accepted crossing also produces a strobe that lasts one clock cycle.

Commutation notches can produce extra comparator transitions near a real crossing. To filter them, each accepted crossing starts a hold-off timer of `HOLD_TICKS` clocks. While the timer runs, the opposite direction is locked out, so a notch gives at most one recorded transition. A crossing that arrives inside the hold-off is discarded, not deferred. The phases are independent and are grouped into buses of width `PHASES`. The default hold-off of 17000 ticks corresponds to about 170 electrical degrees at a 1.8 MHz clock with 50 Hz mains.

Top module: `zxd_top`

## Requirements
- R1: While `rst_n` is low and after its release, every `square` bit reads 0 and every `strobe` bit reads 0 until a crossing is accepted. Reset leaves no hold-off running.
- R2: A comparator rising edge driven just after clock edge N is acted on at edge N+3 (two synchroniser flops and one capture flop). `square` is unchanged after edge N+2.
- R3: An accepted upward crossing (rising edge on `cmp_up[i]`) sets `square[i]` to 1. An accepted downward crossing (rising edge on `cmp_dn[i]`) sets it to 0. `strobe[i]` is 1 for exactly one cycle per accepted crossing.
- R4: Number the cycles from the accepting edge, which is cycle 0. An opposite-direction edge that reaches the capture stage in cycles 1 to `HOLD_TICKS` is dropped. One that reaches it in cycle `HOLD_TICKS`+1 or later is accepted.
- R5: A dropped crossing is discarded. When the hold-off expires, `square[i]` keeps its value until a new comparator rising edge occurs.
- R6: A rising edge in the direction already recorded (upward while `square[i]`=1 after an upward acceptance) gives no strobe, does not change `square[i]` and does not restart the hold-off.
- R7: After reset, the first crossing in either direction is accepted. A first downward crossing gives a strobe with `square[i]` staying 0.
- R8: When upward and downward edges reach capture in the same cycle and both directions are allowed, the upward one is taken and only one strobe is given.
- R9: Each phase has its own synchroniser, level register and timer. A crossing on one phase has no effect on another phase.
- R10: Only rising edges of the comparator signals count. A comparator that falls, at any time, produces no strobe and no change of `square`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_up | input | PHASES | Asynchronous upward-crossing comparator outputs, one per phase |
| cmp_dn | input | PHASES | Asynchronous downward-crossing comparator outputs, one per phase |
| square | output | PHASES | Cleaned square wave per phase: 1 after upward, 0 after downward crossing |
| strobe | output | PHASES | One-cycle pulse per accepted crossing |

## Verification
The bench builds the block with three phases, a two-stage synchroniser and a hold-off of 20 ticks instead of 17000. This brings the lockout boundary within a few dozen cycles. It allows an opposite edge to be placed one cycle before and exactly at the first cycle it is allowed. It also lets one run show a lockout expire, a repeated edge fail to extend it, and a simultaneous pair of edges resolve. The three phases let it show one phase accepting while another is still locked out.

// File: rtl/zxd_pkg.sv
// Package: shared types for the zero-crossing direction detector.
// Assumes nothing beyond a synchronous design context.
package zxd_pkg;

    // Recorded direction of the last accepted crossing of one phase.
    typedef enum logic [1:0] {
        ZX_IDLE = 2'b00,   // nothing accepted since reset
        ZX_HIGH = 2'b01,   // last accepted crossing went upward
        ZX_LOW  = 2'b10    // last accepted crossing went downward
    } zx_level_e;

    // Index of each comparator direction inside a per-phase pair.
    localparam int unsigned DIR_UP = 0;
    localparam int unsigned DIR_DN = 1;
    localparam int unsigned N_DIRS = 2;

endpackage

// File: rtl/zxd_sync.sv
// Module: zxd_sync
// Brings one asynchronous comparator level into the clk domain through a
// chain of STAGES flops. Assumes STAGES >= 2 and a free-running clk; the
// output is delayed by STAGES clock edges.
module zxd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the sampled level through the chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/zxd_edge.sv
// Module: zxd_edge
// Flags the cycle in which a synchronised level goes from 0 to 1.
// Assumes the input is already in the clk domain. Falling edges are not
// reported.
module zxd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic prev;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= lvl;
        end
    end

    assign rise = lvl & ~prev;

endmodule

// File: rtl/zxd_phase.sv
// Module: zxd_phase
// One phase of the detector. It synchronises both comparator signals,
// detects their rising edges and keeps the recorded direction. A single
// down-counter holds off the direction opposite to the last accepted one.
// Assumes HOLD_TICKS >= 4, so that the hold-off is longer than the
// synchroniser latency.
module zxd_phase
    import zxd_pkg::*;
#(
    parameter int unsigned HOLD_TICKS  = 17000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_up,
    input  logic cmp_dn,
    output logic square,
    output logic strobe
);

    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_TICKS);

    logic [N_DIRS-1:0] raw;
    logic [N_DIRS-1:0] synced;
    logic [N_DIRS-1:0] rise;

    zx_level_e     level;
    logic [CW-1:0] hold_cnt;
    logic          hold_idle;
    logic          take_up;
    logic          take_dn;

    assign raw[DIR_UP] = cmp_up;
    assign raw[DIR_DN] = cmp_dn;

    // One synchroniser and edge detector per comparator direction.
    for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
        zxd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw[d]),
            .q     (synced[d])
        );
        zxd_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (synced[d]),
            .rise  (rise[d])
        );
    end

    // Decide whether an edge is accepted; upward wins a tie.
    always_comb begin
        hold_idle = (hold_cnt == '0);
        take_up   = rise[DIR_UP] && (level != ZX_HIGH) && hold_idle;
        take_dn   = rise[DIR_DN] && (level != ZX_LOW)  && hold_idle && !take_up;
    end

    // Record the direction and pulse the strobe on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= ZX_IDLE;
            strobe <= 1'b0;
        end else begin
            strobe <= take_up | take_dn;
            if (take_up) begin
                level <= ZX_HIGH;
            end else if (take_dn) begin
                level <= ZX_LOW;
            end
        end
    end

    // Load the hold-off on acceptance and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (take_up || take_dn) begin
            hold_cnt <= HOLD_LOAD;
        end else if (!hold_idle) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign square = (level == ZX_HIGH);

    // R3: a strobe never lasts two cycles.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe)
        else $error("strobe held longer than one cycle");

    // R3: the square output only moves together with a strobe.
    p_square_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (square != $past(square)) |-> strobe)
        else $error("square changed without strobe");

    // R4: while the hold-off runs, nothing is accepted.
    p_hold_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |=> ($stable(square) && !strobe))
        else $error("crossing accepted inside hold-off");

    // R2: every strobe is preceded by a detected comparator edge.
    p_strobe_has_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(rise[DIR_UP] | rise[DIR_DN]))
        else $error("strobe without a comparator edge");

    // R6: a repeated upward edge while high is ignored.
    p_repeat_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise[DIR_UP] && !rise[DIR_DN] && square) |=> !strobe)
        else $error("repeated upward edge accepted");

endmodule

// File: rtl/zxd_top.sv
// Module: zxd_top
// Zero-crossing direction detector for PHASES independent AC phases. Each
// phase turns two asynchronous comparator signals into a square wave and
// an acceptance strobe, with a hold-off of HOLD_TICKS clocks against the
// opposite direction. Assumes a synchronous active-low reset held for at
// least SYNC_STAGES cycles.
module zxd_top #(
    parameter int unsigned PHASES      = 3,
    parameter int unsigned HOLD_TICKS  = 17000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] cmp_up,
    input  logic [PHASES-1:0] cmp_dn,
    output logic [PHASES-1:0] square,
    output logic [PHASES-1:0] strobe
);

    // One independent detector per phase.
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        zxd_phase #(
            .HOLD_TICKS  (HOLD_TICKS),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_phase (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmp_up (cmp_up[p]),
            .cmp_dn (cmp_dn[p]),
            .square (square[p]),
            .strobe (strobe[p])
        );
    end

endmodule

// File: tb/zxd_top_bench.sv
// Scoreboard bench: stimulus pushes expected strobes, the monitor compares them.
module zxd_top_bench;

    localparam int P    = 3;
    localparam int HOLD = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] cmp_up = '0;
    logic [P-1:0] cmp_dn = '0;
    logic [P-1:0] square;
    logic [P-1:0] strobe;

    typedef struct {
        int    cyc;
        int    ph;
        logic  sq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    zxd_top #(.PHASES(P), .HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u_zxd_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_up (cmp_up),
        .cmp_dn (cmp_dn),
        .square (square),
        .strobe (strobe)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endfunction

    task automatic push(int at, int ph, logic sq, string tag);
        exp_t e;
        e.cyc = at; e.ph = ph; e.sq = sq; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pulse(logic [P-1:0] um, logic [P-1:0] dm);
        cmp_up = cmp_up | um;
        cmp_dn = cmp_dn | dm;
        repeat (2) @(negedge clk);
        cmp_up = cmp_up & ~um;
        cmp_dn = cmp_dn & ~dm;
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: compare every strobe with the queue front.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                check(1'b0, q[0].tag, "missing strobe at cycle", cyc, q[0].cyc);
                void'(q.pop_front());
            end
            for (int p = 0; p < P; p++) begin
                if (strobe[p]) begin
                    if (q.size() == 0 || q[0].cyc != cyc || q[0].ph != p) begin
                        check(1'b0, "R3", "unexpected strobe on phase", p, -1);
                    end else begin
                        check(square[p] == q[0].sq, q[0].tag, "square at strobe",
                              square[p], q[0].sq);
                        void'(q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        int c;
        int s;
        repeat (5) @(negedge clk);
        check(square == '0, "R1", "square in reset", square, 0);
        check(strobe == '0, "R1", "strobe in reset", strobe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: first crossing after reset is downward, accepted, square stays 0
        c = cyc; push(c + 3, 0, 1'b0, "R7");
        pulse(3'b000, 3'b001);
        s = c + 3;

        // R4: upward edge one cycle too early is dropped
        wait_until(s + HOLD - 3);
        pulse(3'b001, 3'b000);
        // R5: dropped edge is not deferred past the hold-off
        wait_until(s + HOLD + 1);
        check(square[0] == 1'b0, "R5", "square after dropped edge", square[0], 0);

        // R2 and R3: fresh upward edge is accepted three edges later
        wait_until(s + HOLD + 2);
        c = cyc; push(c + 3, 0, 1'b1, "R3");
        pulse(3'b001, 3'b000);
        check(square[0] == 1'b0, "R2", "square two edges after input", square[0], 0);
        @(negedge clk);
        check(square[0] == 1'b1, "R2", "square three edges after input", square[0], 1);
        s = c + 3;

        // R6: repeated upward edge ignored and does not restart hold-off
        wait_until(s + 4);
        pulse(3'b001, 3'b000);
        wait_until(s + HOLD - 4);
        check(square[0] == 1'b1, "R6", "square after repeated edge", square[0], 1);
        // R4 boundary: first allowed cycle
        wait_until(s + HOLD - 2);
        c = cyc; push(c + 3, 0, 1'b0, "R4");
        pulse(3'b000, 3'b001);

        // R8: simultaneous edges on idle phase 1, upward wins
        c = cyc; push(c + 3, 1, 1'b1, "R8");
        pulse(3'b010, 3'b010);
        s = c + 3;

        // R9: phase 1 still locked while phase 2 accepts
        wait_until(s + 5);
        c = cyc; push(c + 3, 2, 1'b1, "R9");
        pulse(3'b100, 3'b010);
        s = c + 3;

        // R10: a comparator falling after the hold-off has no effect
        wait_until(s + 2);
        cmp_dn[2] = 1'b1;
        wait_until(s + HOLD + 5);
        cmp_dn[2] = 1'b0;
        repeat (6) @(negedge clk);
        check(square[2] == 1'b1, "R10", "square after falling comparator", square[2], 1);
        check(square[1] == 1'b1, "R9", "phase 1 square after its blocked edge", square[1], 1);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R3", "expected strobes left over", q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule